// File: doc/BRIEF.md
# Address-Dependent Processor Clock Stretcher

This block produces the processor clock (phi2) from one fast master clock, choosing the length of every bus cycle on its own. A down-counter is loaded at the master-clock edge where phi2 goes high. The loaded value sets the full period of that bus cycle. phi2 drops once the counter has run through half of the loaded value. An external address decoder supplies a single flag, `slow_region_i`, which marks addresses that belong to slow peripherals. When the flag is set at the load instant, the long count is loaded. Otherwise the short count is loaded.

With a 24 MHz master clock and the default counts, fast bus cycles run at 6 MHz (4 master clocks) and slow bus cycles at 1 MHz (24 master clocks). The counter is only reloaded once a full cycle has ended. Each high phase and each low phase therefore always has its full length, and a change of speed appears only at a cycle boundary. phi2 comes straight from a flop in the master-clock domain.

A one-clock strobe marks each phi2 rising edge, which lets downstream logic and the bench measure every cycle. The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control signals.

Top module: `cpu_clk_stretcher`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, `phi2_o` and `cyc_start_o` are both 0 after that edge. This holds even if reset arrives in the middle of a bus cycle.
- R2: The first bus cycle after reset begins at the first `clk_i` edge after `rst_i` goes low. That cycle is always fast, whatever the value of `slow_region_i`.
- R3: A cycle whose flag sampled as 0 lasts exactly FAST_CNT master clocks. Its first FAST_CNT/2 clocks have `phi2_o` high (defaults: 4 clocks in total, 2 of them high).
- R4: A cycle whose flag sampled as 1 lasts exactly SLOW_CNT master clocks. Its first SLOW_CNT/2 clocks have `phi2_o` high (defaults: 24 clocks in total, 12 of them high).
- R5: `slow_region_i` is sampled only at the `clk_i` edge where a cycle begins, that is, the edge where `cyc_start_o` becomes 1. Changes to the flag at any other time have no effect on the current cycle.
- R6: `cyc_start_o` is high for exactly one master clock per bus cycle. That clock is the first clock in which `phi2_o` is high. `phi2_o` never rises without it.
- R7: Within a cycle, `phi2_o` forms one unbroken high phase followed by one unbroken low phase. It falls only at the midpoint of the loaded count.
- R8: Cycles follow each other with no gap. The next cycle begins on the clock right after the last low clock of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock (24 MHz in the target use) |
| rst_i | input | 1 | Synchronous reset, active high |
| slow_region_i | input | 1 | Decoded flag: 1 when the current address lies in a slow peripheral region |
| phi2_o | output | 1 | Processor clock, driven from a register |
| cyc_start_o | output | 1 | One-clock strobe in the first clock of each phi2 high phase |

## Verification
The flag is driven in five ways: alternating once per cycle, held low, held high, toggled on every master clock, and following a pseudo-random bit per clock. Alternating and held patterns show that both counts give the right period and falling-edge position, including at every fast-to-slow and slow-to-fast boundary. The two per-clock patterns change the flag in the middle of cycles, so they separate a design that samples only at the load edge from one that follows the flag during the cycle. Reset is applied twice with the flag held high, the second time inside a slow cycle. This confirms the low reset state and that the first cycle after reset is forced to fast speed.

// File: rtl/clkstr_pkg.sv
package clkstr_pkg;

  typedef enum logic {
    SPD_FAST = 1'b0,
    SPD_SLOW = 1'b1
  } speed_e;

  // Width needed to hold a count value up to and including max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/clkstr_period_sel.sv
// Chooses the length of the next bus cycle. The region flag is looked at
// only on the reload clock; the first reload after reset is forced fast.
module clkstr_period_sel
  import clkstr_pkg::*;
#(
  parameter int unsigned FAST_CNT = 4,
  parameter int unsigned SLOW_CNT = 24,
  parameter int unsigned CW       = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          reload_i,
  input  logic          slow_req_i,
  output logic [CW-1:0] load_val_o,
  output speed_e        cur_speed_o
);

  localparam logic [CW-1:0] FAST_V = CW'(FAST_CNT);
  localparam logic [CW-1:0] SLOW_V = CW'(SLOW_CNT);

  logic   first_q;
  speed_e next_speed;
  speed_e speed_q;

  always_comb begin
    if (first_q || !slow_req_i) next_speed = SPD_FAST;
    else                        next_speed = SPD_SLOW;
  end

  always_comb begin
    load_val_o = (next_speed == SPD_SLOW) ? SLOW_V : FAST_V;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      first_q <= 1'b1;
      speed_q <= SPD_FAST;
    end else if (reload_i) begin
      first_q <= 1'b0;
      speed_q <= next_speed;
    end
  end

  assign cur_speed_o = speed_q;

  // R2: the first reload after reset always picks the short count
  a_r2_first_fast: assert property (@(posedge clk_i) disable iff (rst_i)
    (reload_i && first_q) |-> (load_val_o == FAST_V));

  // R5: the speed of a running cycle holds between reloads
  a_r5_speed_held: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(reload_i) && !$past(rst_i)) |-> $stable(speed_q));

endmodule

// File: rtl/clkstr_phase_cnt.sv
// Down-counter for one bus cycle. It also remembers the midpoint of the
// loaded value, so the high-to-low point can be found.
module clkstr_phase_cnt #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] load_val_i,
  output logic          reload_o,
  output logic          mid_hit_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] half_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_q;
  logic [CW-1:0] cnt_dec;

  assign cnt_dec   = cnt_q - ONE;
  assign reload_o  = (cnt_q <= ONE);
  assign mid_hit_o = !reload_o && (cnt_dec == half_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      half_q <= '0;
    end else if (reload_o) begin
      cnt_q  <= load_val_i;
      half_q <= load_val_i >> 1;
    end else begin
      cnt_q  <= cnt_dec;
    end
  end

  assign cnt_o  = cnt_q;
  assign half_o = half_q;

  // R8: while a cycle runs, the count steps down by exactly one each clock
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(cnt_q) > ONE && !$past(rst_i)) |-> (cnt_q == $past(cnt_q) - ONE));

  // R7: the stored midpoint stays fixed for the whole cycle
  a_r7_half_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(cnt_q) > ONE && !$past(rst_i)) |-> $stable(half_q));

endmodule

// File: rtl/cpu_clk_stretcher.sv
module cpu_clk_stretcher
  import clkstr_pkg::*;
#(
  parameter int unsigned FAST_CNT = 4,
  parameter int unsigned SLOW_CNT = 24
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic slow_region_i,
  output logic phi2_o,
  output logic cyc_start_o
);

  localparam int unsigned MAX_CNT = (SLOW_CNT > FAST_CNT) ? SLOW_CNT : FAST_CNT;
  localparam int unsigned CW      = cnt_width(MAX_CNT);

  logic          reload;
  logic          mid_hit;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic [CW-1:0] half;
  speed_e        cur_speed;
  logic          phi2_q;
  logic          stb_q;

  clkstr_period_sel #(
    .FAST_CNT (FAST_CNT),
    .SLOW_CNT (SLOW_CNT),
    .CW       (CW)
  ) u_sel (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .reload_i    (reload),
    .slow_req_i  (slow_region_i),
    .load_val_o  (load_val),
    .cur_speed_o (cur_speed)
  );

  clkstr_phase_cnt #(
    .CW (CW)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_val_i (load_val),
    .reload_o   (reload),
    .mid_hit_o  (mid_hit),
    .cnt_o      (cnt),
    .half_o     (half)
  );

  // phi2 and the strobe come straight from flops
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phi2_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= reload;
      if (reload)       phi2_q <= 1'b1;
      else if (mid_hit) phi2_q <= 1'b0;
    end
  end

  assign phi2_o      = phi2_q;
  assign cyc_start_o = stb_q;

  // R6: every rise of phi2 comes with the strobe
  a_r6_rise_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(phi2_q) |-> stb_q);

  // R6: the strobe lasts a single master clock
  a_r6_strobe_single: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_q |=> !stb_q);

  // R7: phi2 falls only when the counter sits at the midpoint
  a_r7_fall_mid: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(phi2_q) |-> (cnt == half));

  // R3/R4: a fresh cycle holds one of the two configured lengths
  a_r4_load_legal: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_q |-> ((cnt == CW'(FAST_CNT) && cur_speed == SPD_FAST) ||
               (cnt == CW'(SLOW_CNT) && cur_speed == SPD_SLOW)));

endmodule

// File: tb/cpu_clk_stretcher_tb_top.sv
module cpu_clk_stretcher_tb_top;

  localparam int FAST = 4;
  localparam int SLOW = 24;

  logic clk = 1'b0;
  logic rst;
  logic flag;
  logic phi2;
  logic stb;

  int checks = 0;
  int errors = 0;
  int mode   = 1;
  int strobes = 0;
  bit in_meas = 0;
  bit after_rst = 0;
  bit cur_slow = 0;
  int per_cnt = 0;
  int hi_cnt = 0;
  int lo_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  cpu_clk_stretcher #(.FAST_CNT(FAST), .SLOW_CNT(SLOW)) dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .slow_region_i (flag),
    .phi2_o        (phi2),
    .cyc_start_o   (stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor and flag driver, 2 ns after each rising edge
  always @(posedge clk) begin
    bit flag_at_edge;
    int exp_len;
    #2;
    flag_at_edge = flag;
    if (rst) begin
      in_meas = 0;
    end else begin
      if (stb) begin
        if (in_meas) begin
          exp_len = cur_slow ? SLOW : FAST;
          // R3 / R4 / R8: period with no gap, high phase at midpoint
          check(per_cnt == exp_len, cur_slow ? "R4 period" : "R3 period", per_cnt, exp_len);
          check(hi_cnt == exp_len / 2, cur_slow ? "R4 high time" : "R3 high time", hi_cnt, exp_len / 2);
        end
        // R6: phi2 is high in the strobe clock
        check(phi2 == 1'b1, "R6 phi2 high with strobe", phi2, 1);
        // R5 / R2: speed set by flag at this edge, forced fast after reset
        cur_slow = after_rst ? 1'b0 : flag_at_edge;
        after_rst = 0;
        per_cnt = 1;
        hi_cnt = 1;
        lo_seen = 0;
        in_meas = 1;
        strobes++;
        if (mode == 0) flag = ~flag;
      end else if (in_meas) begin
        per_cnt++;
        if (phi2) begin
          hi_cnt++;
          // R7: no high clock after the low phase has begun
          if (lo_seen != 0) check(1'b0, "R7 phi2 rose mid cycle", 1, 0);
        end else begin
          lo_seen = 1;
        end
        if (per_cnt > SLOW + 2) check(1'b0, "R8 cycle too long", per_cnt, SLOW);
      end
      case (mode)
        1: flag = 1'b0;
        2: flag = 1'b1;
        3: flag = ~flag;
        4: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          flag = lfsr[0];
        end
        default: ;
      endcase
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    flag = 1'b1;
    mode = 5;
    repeat (3) @(negedge clk);
    // R1: outputs low under reset
    check(phi2 == 1'b0, "R1 phi2 in reset", phi2, 0);
    check(stb == 1'b0, "R1 strobe in reset", stb, 0);
    rst = 1'b0;
    after_rst = 1;
    @(posedge clk);
    #3;
    // R2: first cycle begins on the first edge after release
    check(stb == 1'b1, "R2 first strobe", stb, 1);
  endtask

  task automatic run_mode(input int m, input int n);
    int start;
    mode = m;
    start = strobes;
    while (strobes < start + n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    flag = 1'b1;
    do_reset();
    run_mode(0, 30);
    run_mode(1, 20);
    run_mode(2, 10);
    run_mode(3, 40);
    run_mode(4, 60);
    // reset in the middle of a slow cycle
    mode = 2;
    while (!stb) @(negedge clk);
    repeat (6) @(negedge clk);
    do_reset();
    run_mode(0, 20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", strobes, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule